// File: doc/BRIEF.md
# Phase-Staggered Flicker Stimulus Display

This block drives a 640x480 raster display and paints a four-target visual stimulus on it. A square sits near each of the top, bottom, left and right edges of the screen, and each carries a small block-style digit naming it. Once started, all four squares blink at one shared rate. Each square starts later than the one before it by a fixed phase offset, so at any instant the squares sit at different points of the same blink cycle. A one-clock trigger pulse, one line per target, marks every black-to-white switch. These pulses let a downstream acquisition path time-lock its samples to each target.

A run is a fixed number of rounds. In each round every target blinks a set number of times, and a pause separates one round from the next. After the last round the display goes quiet until the next start. A red square cursor can be sent to any of the four targets. It glides there one pixel per axis on a divided clock, and it is drawn above everything else.

All raster geometry, blink half-period, phase offset, blink count, pause length, round count, square and cursor sizes and the cursor step divider are parameters. The defaults give standard 640x480 timing from a 25.175 MHz pixel clock.

Top module: `flicker_stim_top`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks (default 800, about 31.469 kHz at 25.175 MHz). hsync_n is low for H_SYNC clocks, starting at column H_ACTIVE+H_FP. All outputs show pixel index p on the clock after the p-th clock following reset release, where column = p mod line length.
- R2: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines (default 525, about 59.94 Hz). vsync_n is low during lines V_ACTIVE+V_FP up to V_ACTIVE+V_FP+V_SYNC-1.
- R3: red, green and blue are all zero whenever the pixel lies outside columns 0..H_ACTIVE-1 or lines 0..V_ACTIVE-1.
- R4: An active pixel not covered by a square, digit or cursor shows dark slate gray (R,G,B) = (47,79,79).
- R5: Target 0 is centred at the top, target 1 at the bottom, target 2 at the left and target 3 at the right. Each is an SQ_SIZE square inset MARGIN pixels from its edge. A 3x5 glyph of the target's digit is drawn in gray (128,128,128), offset by ((SQ_SIZE-3)/2, (SQ_SIZE-5)/2) within the square. The rest of the square is white (255,255,255) while its blink signal is high and black while it is low.
- R6: Within a round each target blinks FLASHES times with period 2*HALF_PERIOD clocks. It is white for the first HALF_PERIOD clocks of each period and black otherwise.
- R7: Target k begins its first blink of a round k*PHASE_OFS clocks after target 0. The default PHASE_OFS is a quarter of the blink period.
- R8: trig[k] (bit index = target number) is high for exactly one clock, the first clock on which square k shows white after black. Target 0's first trigger appears two clocks after the clock on which start is sampled high.
- R9: Consecutive rounds start (3*PHASE_OFS + FLASHES*2*HALF_PERIOD) + 1 + PAUSE_LEN clocks apart, and no target blinks in between.
- R10: After ROUNDS rounds all squares stay black with no triggers. start is ignored while a run is in progress.
- R11: The cursor is a red (255,0,0) CUR_SIZE square drawn over all other shapes. It starts at the screen centre. A move pulse sends it to the target named by move_tgt, with its top-left corner at the target's corner plus (SQ_SIZE-CUR_SIZE)/2 on each axis. It steps at most one pixel per axis every CUR_DIV clocks.
- R12: While rst is high, hsync_n and vsync_n are high and red, green, blue and trig are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run of blink rounds when idle |
| move | input | 1 | One-clock cursor move command |
| move_tgt | input | 2 | Target number the cursor heads to |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |
| trig | output | 4 | Per-target black-to-white pulse |

## Verification
The cursor and a blinking square can claim the same pixel in the same clock. This happens when the cursor is parked on target 0 before a run starts. While the run is active, the pixels under the cursor must read pure red, and the uncovered part of the same square must follow the blink timing predicted from the start clock. The bench also issues a second start in the middle of the second round. It then judges the trigger train against its own clock-count prediction, which assumes the pulse was ignored.

// File: rtl/stim_pkg.sv
package stim_pkg;

    localparam int COORD_W = 12;
    localparam int NUM_TGT = 4;
    localparam int CH_W    = 8;

    typedef logic [COORD_W-1:0] coord_t;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } point_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FLASH = 2'd1,
        SEQ_PAUSE = 2'd2
    } seq_state_e;

    localparam rgb_t COL_BLACK = '{r: 8'd0,   g: 8'd0,   b: 8'd0};
    localparam rgb_t COL_WHITE = '{r: 8'd255, g: 8'd255, b: 8'd255};
    localparam rgb_t COL_BG    = '{r: 8'd47,  g: 8'd79,  b: 8'd79};
    localparam rgb_t COL_RED   = '{r: 8'd255, g: 8'd0,   b: 8'd0};
    localparam rgb_t COL_GLYPH = '{r: 8'd128, g: 8'd128, b: 8'd128};

    // Target placement: 0 top, 1 bottom, 2 left, 3 right
    function automatic int tgt_x(input int k, input int ha, input int sq, input int mg);
        case (k)
            0, 1:    return (ha - sq) / 2;
            2:       return mg;
            default: return ha - mg - sq;
        endcase
    endfunction

    function automatic int tgt_y(input int k, input int va, input int sq, input int mg);
        case (k)
            0:       return mg;
            1:       return va - mg - sq;
            default: return (va - sq) / 2;
        endcase
    endfunction

    // 3 wide x 5 tall digit art, row 0 in the top three bits
    function automatic logic [14:0] glyph_bits(input logic [1:0] d);
        case (d)
            2'd0:    return 15'b111_101_101_101_111;
            2'd1:    return 15'b010_110_010_010_111;
            2'd2:    return 15'b111_001_111_100_111;
            default: return 15'b111_001_111_001_111;
        endcase
    endfunction

    function automatic logic glyph_pixel(input logic [1:0] d, input logic [2:0] col,
                                         input logic [2:0] row);
        logic [14:0] bits;
        logic [3:0]  idx;
        bits = glyph_bits(d);
        idx  = 4'd14 - (4'(row) * 4'd3 + 4'(col));
        return bits[idx];
    endfunction

endpackage

// File: rtl/stim_vga_timing.sv
module stim_vga_timing
    import stim_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33
) (
    input  logic   clk,
    input  logic   rst,
    output coord_t hcnt,
    output coord_t vcnt,
    output logic   active,
    output logic   hs_n,
    output logic   vs_n
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HS_BEG  = H_ACTIVE + H_FP;
    localparam int VS_BEG  = V_ACTIVE + V_FP;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (hcnt == coord_t'(H_TOTAL - 1)) begin
            hcnt <= '0;
            vcnt <= (vcnt == coord_t'(V_TOTAL - 1)) ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    assign active = (hcnt < coord_t'(H_ACTIVE)) && (vcnt < coord_t'(V_ACTIVE));
    assign hs_n   = !((hcnt >= coord_t'(HS_BEG)) && (hcnt < coord_t'(HS_BEG + H_SYNC)));
    assign vs_n   = !((vcnt >= coord_t'(VS_BEG)) && (vcnt < coord_t'(VS_BEG + V_SYNC)));

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (hcnt == coord_t'(H_TOTAL - 1)) |=> (hcnt == '0)); // R1
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hcnt != coord_t'(H_TOTAL - 1)) |=> $stable(vcnt)); // R2
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (hcnt == coord_t'(H_TOTAL - 1) && vcnt == coord_t'(V_TOTAL - 1)) |=> (vcnt == '0)); // R2

endmodule

// File: rtl/stim_flash_seq.sv
module stim_flash_seq
    import stim_pkg::*;
#(
    parameter int HALF_PERIOD = 6293750,
    parameter int PHASE_OFS   = HALF_PERIOD / 2,
    parameter int FLASHES     = 10,
    parameter int PAUSE_LEN   = 75525000,
    parameter int ROUNDS      = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic [NUM_TGT-1:0] flash,
    output logic [NUM_TGT-1:0] trig
);
    localparam int PERIOD    = 2 * HALF_PERIOD;
    localparam int ROUND_LEN = (NUM_TGT - 1) * PHASE_OFS + FLASHES * PERIOD;
    localparam int CW        = $clog2(ROUND_LEN + 1);
    localparam int PW        = $clog2(PAUSE_LEN + 1);
    localparam int RW        = $clog2(ROUNDS + 1);
    localparam int PHW       = $clog2(PERIOD);
    localparam int FW        = $clog2(FLASHES + 1);

    seq_state_e     state;
    logic [CW-1:0]  cnt;
    logic [PW-1:0]  pcnt;
    logic [RW-1:0]  rounds;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            cnt    <= '0;
            pcnt   <= '0;
            rounds <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    state  <= SEQ_FLASH;
                    cnt    <= '0;
                    rounds <= '0;
                end
                SEQ_FLASH: if (cnt == CW'(ROUND_LEN)) begin
                    cnt    <= '0;
                    rounds <= rounds + 1'b1;
                    if (rounds == RW'(ROUNDS - 1)) begin
                        state <= SEQ_IDLE;
                    end else begin
                        state <= SEQ_PAUSE;
                        pcnt  <= '0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
                SEQ_PAUSE: if (pcnt == PW'(PAUSE_LEN - 1)) begin
                    state <= SEQ_FLASH;
                    cnt   <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // One phase-delayed blink generator per target, launched off the round counter
    for (genvar k = 0; k < NUM_TGT; k++) begin : g_tgt
        localparam logic [CW-1:0] LAUNCH = CW'(k * PHASE_OFS);
        logic           run;
        logic [PHW-1:0] ph;
        logic [FW-1:0]  fc;

        always_ff @(posedge clk) begin
            if (rst) begin
                run <= 1'b0;
                ph  <= '0;
                fc  <= '0;
            end else if (state == SEQ_FLASH && cnt == LAUNCH) begin
                run <= 1'b1;
                ph  <= '0;
                fc  <= '0;
            end else if (run) begin
                if (ph == PHW'(PERIOD - 1)) begin
                    ph <= '0;
                    if (fc == FW'(FLASHES - 1)) run <= 1'b0;
                    else fc <= fc + 1'b1;
                end else begin
                    ph <= ph + 1'b1;
                end
            end
        end

        assign flash[k] = run && (ph < PHW'(HALF_PERIOD));
        assign trig[k]  = run && (ph == '0);

        AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (rst)
            trig[k] |=> !trig[k]); // R8
    end

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE) |-> (flash == '0)); // R10

endmodule

// File: rtl/stim_cursor.sv
module stim_cursor
    import stim_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int V_ACTIVE = 480,
    parameter int SQ_SIZE  = 96,
    parameter int MARGIN   = 16,
    parameter int CUR_SIZE = 16,
    parameter int CUR_DIV  = 50000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       move,
    input  logic [1:0] move_tgt,
    output point_t     pos
);
    localparam int DW    = $clog2(CUR_DIV + 1);
    localparam int INSET = (SQ_SIZE - CUR_SIZE) / 2;
    localparam point_t HOME = '{x: coord_t'((H_ACTIVE - CUR_SIZE) / 2),
                                y: coord_t'((V_ACTIVE - CUR_SIZE) / 2)};

    point_t        dest;
    logic [DW-1:0] div;

    function automatic point_t dest_of(input logic [1:0] t);
        point_t d;
        d.x = coord_t'(tgt_x(int'(t), H_ACTIVE, SQ_SIZE, MARGIN) + INSET);
        d.y = coord_t'(tgt_y(int'(t), V_ACTIVE, SQ_SIZE, MARGIN) + INSET);
        return d;
    endfunction

    function automatic coord_t step_to(input coord_t cur, input coord_t dst);
        if (cur < dst) return cur + 1'b1;
        if (cur > dst) return cur - 1'b1;
        return cur;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= HOME;
            dest <= HOME;
            div  <= '0;
        end else begin
            if (move) dest <= dest_of(move_tgt);
            if (div == DW'(CUR_DIV - 1)) begin
                div   <= '0;
                pos.x <= step_to(pos.x, dest.x);
                pos.y <= step_to(pos.y, dest.y);
            end else begin
                div <= div + 1'b1;
            end
        end
    end

    AST_CUR_STEP_X: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pos.x == $past(pos.x) || pos.x == $past(pos.x) + 1'b1
                  || pos.x == $past(pos.x) - 1'b1)); // R11
    AST_CUR_STEP_Y: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pos.y == $past(pos.y) || pos.y == $past(pos.y) + 1'b1
                  || pos.y == $past(pos.y) - 1'b1)); // R11

endmodule

// File: rtl/flicker_stim_top.sv
module flicker_stim_top
    import stim_pkg::*;
#(
    parameter int H_ACTIVE    = 640,
    parameter int H_FP        = 16,
    parameter int H_SYNC      = 96,
    parameter int H_BP        = 48,
    parameter int V_ACTIVE    = 480,
    parameter int V_FP        = 10,
    parameter int V_SYNC      = 2,
    parameter int V_BP        = 33,
    parameter int SQ_SIZE     = 96,
    parameter int MARGIN      = 16,
    parameter int CUR_SIZE    = 16,
    parameter int CUR_DIV     = 50000,
    parameter int HALF_PERIOD = 6293750,
    parameter int PHASE_OFS   = HALF_PERIOD / 2,
    parameter int FLASHES     = 10,
    parameter int PAUSE_LEN   = 75525000,
    parameter int ROUNDS      = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       move,
    input  logic [1:0] move_tgt,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic [7:0] red,
    output logic [7:0] green,
    output logic [7:0] blue,
    output logic [3:0] trig
);
    localparam int GX = (SQ_SIZE - 3) / 2;
    localparam int GY = (SQ_SIZE - 5) / 2;

    coord_t             hcnt, vcnt;
    logic               active, hs_n, vs_n;
    logic [NUM_TGT-1:0] flash, trig_raw, in_sq, in_gl;
    point_t             cur;
    logic               in_cur;
    rgb_t               pix, pix_q;
    logic               hs_q, vs_q;
    logic [NUM_TGT-1:0] trig_q;

    stim_vga_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
    ) u_timing (
        .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
        .active(active), .hs_n(hs_n), .vs_n(vs_n)
    );

    stim_flash_seq #(
        .HALF_PERIOD(HALF_PERIOD), .PHASE_OFS(PHASE_OFS), .FLASHES(FLASHES),
        .PAUSE_LEN(PAUSE_LEN), .ROUNDS(ROUNDS)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .flash(flash), .trig(trig_raw)
    );

    stim_cursor #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .SQ_SIZE(SQ_SIZE),
        .MARGIN(MARGIN), .CUR_SIZE(CUR_SIZE), .CUR_DIV(CUR_DIV)
    ) u_cursor (
        .clk(clk), .rst(rst), .move(move), .move_tgt(move_tgt), .pos(cur)
    );

    // Per-target shape hit tests
    for (genvar k = 0; k < NUM_TGT; k++) begin : g_shape
        localparam int OX = tgt_x(k, H_ACTIVE, SQ_SIZE, MARGIN);
        localparam int OY = tgt_y(k, V_ACTIVE, SQ_SIZE, MARGIN);
        logic       in_box;
        logic [2:0] gcol, grow;

        assign in_sq[k] = (hcnt >= coord_t'(OX)) && (hcnt < coord_t'(OX + SQ_SIZE))
                       && (vcnt >= coord_t'(OY)) && (vcnt < coord_t'(OY + SQ_SIZE));
        assign in_box   = (hcnt >= coord_t'(OX + GX)) && (hcnt < coord_t'(OX + GX + 3))
                       && (vcnt >= coord_t'(OY + GY)) && (vcnt < coord_t'(OY + GY + 5));
        assign gcol     = 3'(hcnt - coord_t'(OX + GX));
        assign grow     = 3'(vcnt - coord_t'(OY + GY));
        assign in_gl[k] = in_box && glyph_pixel(2'(k), gcol, grow);
    end

    assign in_cur = (hcnt >= cur.x) && (hcnt < cur.x + coord_t'(CUR_SIZE))
                 && (vcnt >= cur.y) && (vcnt < cur.y + coord_t'(CUR_SIZE));

    // Layer priority: blanking, cursor, digit, lit square, dark square, background
    always_comb begin
        if (!active)                pix = COL_BLACK;
        else if (in_cur)            pix = COL_RED;
        else if (|in_gl)            pix = COL_GLYPH;
        else if (|(in_sq & flash))  pix = COL_WHITE;
        else if (|in_sq)            pix = COL_BLACK;
        else                        pix = COL_BG;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q   <= 1'b1;
            vs_q   <= 1'b1;
            pix_q  <= COL_BLACK;
            trig_q <= '0;
        end else begin
            hs_q   <= hs_n;
            vs_q   <= vs_n;
            pix_q  <= pix;
            trig_q <= trig_raw;
        end
    end

    assign hsync_n = hs_q;
    assign vsync_n = vs_q;
    assign red     = pix_q.r;
    assign green   = pix_q.g;
    assign blue    = pix_q.b;
    assign trig    = trig_q;

    AST_SYNC_BLANK: assert property (@(posedge clk) disable iff (rst)
        (!hsync_n || !vsync_n) |-> (red == '0 && green == '0 && blue == '0)); // R3
    AST_TRIG_LIT: assert property (@(posedge clk) disable iff (rst)
        (trig_raw != '0) |-> ((trig_raw & flash) == trig_raw)); // R8

endmodule

// File: tb/flicker_stim_top_bench.sv
module flicker_stim_top_bench;

    localparam int HA = 64, HF = 4, HS = 8, HB = 4;
    localparam int VA = 48, VF = 2, VS = 2, VB = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int SQ = 8, MG = 2, CS = 4, CD = 2;
    localparam int HALF = 64, OFS = 32, NF = 3, PAUSE = 200, NR = 4;
    localparam int PER = 2 * HALF;
    localparam int RL  = 3 * OFS + NF * PER;
    localparam int RP  = RL + 1 + PAUSE;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       move = 1'b0;
    logic [1:0] move_tgt = 2'd0;
    logic       hsync_n, vsync_n;
    logic [7:0] red, green, blue;
    logic [3:0] trig;

    int vectors = 0;
    int errors  = 0;
    int kcnt    = 0;
    int s_edge  = -1;
    bit cur_ok  = 1'b0;
    bit sq_en   = 1'b1;
    int cur_x   = 0;
    int cur_y   = 0;

    flicker_stim_top #(
        .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
        .SQ_SIZE(SQ), .MARGIN(MG), .CUR_SIZE(CS), .CUR_DIV(CD),
        .HALF_PERIOD(HALF), .PHASE_OFS(OFS), .FLASHES(NF),
        .PAUSE_LEN(PAUSE), .ROUNDS(NR)
    ) u_flicker_stim_top (
        .clk(clk), .rst(rst), .start(start), .move(move), .move_tgt(move_tgt),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .red(red), .green(green),
        .blue(blue), .trig(trig)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) kcnt = 0;
        else     kcnt = kcnt + 1;
    end

    function automatic int ox(input int k);
        if (k <= 1) return (HA - SQ) / 2;
        if (k == 2) return MG;
        return HA - MG - SQ;
    endfunction

    function automatic int oy(input int k);
        if (k == 0) return MG;
        if (k == 1) return VA - MG - SQ;
        return (VA - SQ) / 2;
    endfunction

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at k=%0d: actual=%0h expected=%0h", req, kcnt, act, exp);
        end
    endtask

    // Offset of sample from target k's first expected trigger; -1 when outside any run
    function automatic int rel_pos(input int k, output int rnd);
        int d;
        rnd = NR;
        if (s_edge < 0) return -1;
        d = kcnt - (s_edge + 2) - k * OFS;
        if (d < 0) return -1;
        rnd = d / RP;
        if (rnd >= NR) return -1;
        return d % RP;
    endfunction

    task automatic sample_check();
        int p, h, v, pix, rem, rnd;
        bit in_any;
        p   = kcnt - 1;
        h   = p % HT;
        v   = (p / HT) % VT;
        pix = {red, green, blue};
        chk("R1", hsync_n == !(h >= HA + HF && h < HA + HF + HS), hsync_n,
            !(h >= HA + HF && h < HA + HF + HS));
        chk("R2", vsync_n == !(v >= VA + VF && v < VA + VF + VS), vsync_n,
            !(v >= VA + VF && v < VA + VF + VS));
        in_any = 1'b0;
        for (int k = 0; k < 4; k++)
            if (h >= ox(k) && h < ox(k) + SQ && v >= oy(k) && v < oy(k) + SQ) in_any = 1'b1;
        if (!(h < HA && v < VA)) begin
            chk("R3", pix == 0, pix, 0);
        end else if (cur_ok && h >= cur_x && h < cur_x + CS && v >= cur_y && v < cur_y + CS) begin
            chk("R11", pix == 24'hFF0000, pix, 24'hFF0000);
        end else if (h < 28 && v < 20 && !in_any) begin
            chk("R4", pix == 24'h2F4F4F, pix, 24'h2F4F4F);
        end else begin
            for (int k = 0; k < 4; k++) begin
                if (h == ox(k) + 3 && v == oy(k) + 1) begin
                    chk("R5", pix == 24'h808080, pix, 24'h808080);
                end else if (sq_en && h >= ox(k) && h < ox(k) + SQ && v >= oy(k)
                             && v < oy(k) + SQ
                             && !(h >= ox(k) + 2 && h < ox(k) + 5 && v >= oy(k) + 1
                                  && v < oy(k) + 6)) begin
                    rem = rel_pos(k, rnd);
                    if (rem >= 0 && rem < NF * PER && (rem % PER) < HALF)
                        chk("R5", pix == 24'hFFFFFF, pix, 24'hFFFFFF);
                    else
                        chk("R5", pix == 0, pix, 0);
                end
            end
        end
        for (int k = 0; k < 4; k++) begin
            bit exp_t;
            rem   = rel_pos(k, rnd);
            exp_t = (rem >= 0 && rem < NF * PER && (rem % PER) == 0);
            if (exp_t)                       chk("R8", trig[k] == exp_t, trig[k], exp_t);
            else if (s_edge < 0 || rnd >= NR) chk("R10", trig[k] == exp_t, trig[k], exp_t);
            else if (rem >= NF * PER)        chk("R9", trig[k] == exp_t, trig[k], exp_t);
            else if (k > 0 && rem < 0)       chk("R7", trig[k] == exp_t, trig[k], exp_t);
            else                             chk("R6", trig[k] == exp_t, trig[k], exp_t);
        end
    endtask

    task automatic run_cycles(input int n);
        repeat (n) begin
            @(negedge clk);
            sample_check();
        end
    endtask

    // R12: idle outputs while reset is held
    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12", hsync_n == 1'b1, hsync_n, 1);
        chk("R12", vsync_n == 1'b1, vsync_n, 1);
        chk("R12", {red, green, blue} == 24'h0, {red, green, blue}, 0);
        chk("R12", trig == 4'h0, trig, 0);
        rst = 1'b0;
        run_cycles(20);
    endtask

    task automatic cursor_to(input logic [1:0] t, input int ex, input int ey);
        cur_ok = 1'b0;
        sq_en  = 1'b0;
        @(negedge clk);
        move     = 1'b1;
        move_tgt = t;
        @(negedge clk);
        move = 1'b0;
        run_cycles(120);
        cur_x  = ex;
        cur_y  = ey;
        cur_ok = 1'b1;
        sq_en  = 1'b1;
    endtask

    // R11: park cursor on target 0, where it overlaps the square
    task automatic test_cursor_top();
        cursor_to(2'd0, 30, 4);
        run_cycles(40);
    endtask

    // R6 R7 R8 R9 R10: full run with a stray start in round two
    task automatic test_flash_run();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        s_edge = kcnt;
        start  = 1'b0;
        run_cycles(RP + 100);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        run_cycles(3 * RP + 2000);
    endtask

    // R11: glide to target 3 and scan a full frame
    task automatic test_cursor_right();
        cursor_to(2'd3, 56, 22);
        run_cycles(HT * VT + 10);
    endtask

    initial begin
        test_reset();
        test_cursor_top();
        test_flash_run();
        test_cursor_right();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule